// File: doc/BRIEF.md
# Two-wire serial EEPROM slave

This block is a two-wire bus slave that behaves like a byte-addressed serial EEPROM. The storage is a register array of 2^ADDR_W bytes, 4096 by default. It watches oversampled copies of the clock line and the data line and finds start and stop conditions. It answers to a 7-bit device address made of a fixed type code and a 3-bit strap. It shifts bytes in and out MSB first and answers on the ninth clock of each byte. The only output is an enable that pulls the data line low. Outside the block, the line is wired-AND with the master.

A write carries a two-byte word address, high byte first, followed by data bytes. The data bytes go into a page buffer. The stop that ends the write starts an internal write cycle that lasts WR_CYCLES system clocks. During that cycle the buffered bytes are copied into the array one per clock, and the device does not acknowledge its address, so a master can poll it until it answers again. Reads return the byte at an internal address counter. The master picks the read form: a current-address read, a random read (a write header followed by a repeated start), or a sequential read that continues for as long as the master acknowledges.

There is no data stream at this block's edge and therefore no valid/ready pair. Flow control belongs to the bus itself: the master sets the pace with the clock line, and the slave holds the master off by withholding its acknowledge.

Top module: `twi_ee_slave`

## Requirements
- R1: The device address byte is sent MSB first. Bits 7..4 are 1010, bits 3..1 equal dev_strap_i, and bit 0 is R/W (1 = read). When the byte matches and no write cycle is running, the slave pulls the data line low during the ninth clock. On a mismatch it does not pull the line at any time until the next start.
- R2: From the stop that ends a write that loaded at least one byte, and for WR_CYCLES clocks after it, a matching address byte of either R/W value gets no acknowledge. After that window it is acknowledged again.
- R3: In write form, the slave acknowledges two word-address bytes, high byte then low byte, and every data byte after them. The word address is the low ADDR_W bits of {high, low}, and any upper bits are ignored.
- R4: Each data byte is stored at the counter's offset within its 2^PAGE_W-byte page. The offset then steps up and wraps inside the same page, so after a write the counter holds the last written address plus one, taken within that page.
- R5: The write cycle changes only the bytes that were loaded. Every other byte in the page keeps its value.
- R6: In read form, after the address acknowledge the slave sends 8 bits MSB first: the byte at the counter. The counter advances by one after each byte sent.
- R7: In reads, the counter wraps from the last array address to address 0.
- R8: A sequential read continues while the master pulls the line low on each ninth clock. When the line is high on a ninth clock, the slave stops driving until the next start.
- R9: A random read works as follows. A write-form header with a word address, followed by a repeated start and a read-form address byte, returns data starting at that word address.
- R10: A stop condition releases the data line on the next clock. The pull enable changes only while the synchronised clock line is low.
- R11: After reset, the data line is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level (wired-AND result) |
| dev_strap_i | input | 3 | Low device address bits |
| sda_pull_o | output | 1 | 1 pulls the data line low |

## Verification
The bench builds the block with ADDR_W = 8, PAGE_W = 5 and WR_CYCLES = 300. A 256-byte array lets a short run cover the wrap of the read counter from the last address to 0. The 32-byte page keeps the wrap of a write inside its page and the partial-page commit close at hand. A write cycle of 300 clocks is long enough for a poll issued straight after the stop to land inside the busy window, and short enough for a second poll to come after it.

// File: rtl/twi_ee_pkg.sv
package twi_ee_pkg;
  typedef enum logic [3:0] {
    S_IDLE, S_DEV, S_DACK, S_AHI, S_AHACK, S_ALO, S_ALACK,
    S_WDAT, S_WACK, S_RDAT, S_RACK
  } phase_t;
  localparam logic [3:0] DEV_TYPE = 4'b1010;
endpackage

// File: rtl/twi_ee_line_sense.sv
module twi_ee_line_sense (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [1:0] scl_sy, sda_sy;
  logic       scl_p, sda_p;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sy <= 2'b11;
      sda_sy <= 2'b11;
      scl_p  <= 1'b1;
      sda_p  <= 1'b1;
    end else begin
      scl_sy <= {scl_sy[0], scl_i};
      sda_sy <= {sda_sy[0], sda_i};
      scl_p  <= scl_sy[1];
      sda_p  <= sda_sy[1];
    end
  end

  assign scl_s     = scl_sy[1];
  assign sda_s     = sda_sy[1];
  assign scl_rise  = scl_s & ~scl_p;
  assign scl_fall  = ~scl_s & scl_p;
  assign start_det = scl_s & scl_p & sda_p & ~sda_s;
  assign stop_det  = scl_s & scl_p & ~sda_p & sda_s;
endmodule

// File: rtl/twi_ee_wcycle.sv
module twi_ee_wcycle #(
  parameter int WR_CYCLES = 5000,
  parameter int PAGE_W    = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  output logic              busy,
  output logic              commit_act,
  output logic [PAGE_W-1:0] commit_idx
);
  localparam int CNT_W = $clog2(WR_CYCLES + 1);
  localparam int PAGE  = 1 << PAGE_W;

  logic [CNT_W-1:0] cnt;
  logic             run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run <= 1'b0;
      cnt <= '0;
    end else if (go && !run) begin
      run <= 1'b1;
      cnt <= '0;
    end else if (run) begin
      if (cnt == CNT_W'(WR_CYCLES - 1)) run <= 1'b0;
      else                              cnt <= cnt + 1'b1;
    end
  end

  assign busy       = run;
  assign commit_act = run && (int'(cnt) < PAGE);
  assign commit_idx = PAGE_W'(cnt);
endmodule

// File: rtl/twi_ee_store.sv
module twi_ee_store #(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [7:0]        wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [7:0]        rdata
);
  localparam int DEPTH = 1 << ADDR_W;
  logic [7:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we) cells[waddr] <= wdata;
  end

  assign rdata = cells[raddr];
endmodule

// File: rtl/twi_ee_slave.sv
module twi_ee_slave #(
  parameter int ADDR_W    = 12,
  parameter int PAGE_W    = 5,
  parameter int WR_CYCLES = 5000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic [2:0] dev_strap_i,
  output logic       sda_pull_o
);
  import twi_ee_pkg::*;
  localparam int PAGE = 1 << PAGE_W;

  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic busy, commit_act, mem_we, go, wr_take, rw;
  logic [PAGE_W-1:0] commit_idx;
  logic [ADDR_W-1:0] ptr, waddr;
  logic [7:0] shreg, ahi, tx, rd_data, wdata;
  logic [15:0] full_addr;
  logic [3:0] bcnt;
  logic [PAGE-1:0] pvalid;
  logic [7:0] pbuf [PAGE];
  logic drive;
  phase_t phase;

  twi_ee_line_sense u_sense (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  twi_ee_wcycle #(.WR_CYCLES(WR_CYCLES), .PAGE_W(PAGE_W)) u_wcyc (
    .clk(clk), .rst_n(rst_n), .go(go), .busy(busy),
    .commit_act(commit_act), .commit_idx(commit_idx)
  );

  twi_ee_store #(.ADDR_W(ADDR_W)) u_store (
    .clk(clk), .we(mem_we), .waddr(waddr), .wdata(wdata),
    .raddr(ptr), .rdata(rd_data)
  );

  assign go        = stop_det && (|pvalid) && !busy;
  assign mem_we    = commit_act && pvalid[commit_idx];
  assign waddr     = {ptr[ADDR_W-1:PAGE_W], commit_idx};
  assign wdata     = pbuf[commit_idx];
  assign full_addr = {ahi, shreg};
  assign wr_take   = (phase == S_WDAT) && scl_fall && (bcnt == 4'd8)
                     && !start_det && !stop_det;
  assign sda_pull_o = drive;

  always_ff @(posedge clk) begin
    if (wr_take) pbuf[ptr[PAGE_W-1:0]] <= shreg;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase  <= S_IDLE;
      bcnt   <= '0;
      shreg  <= '0;
      ahi    <= '0;
      tx     <= '0;
      ptr    <= '0;
      rw     <= 1'b0;
      drive  <= 1'b0;
      pvalid <= '0;
    end else begin
      if (commit_act) pvalid[commit_idx] <= 1'b0;
      if (start_det) begin
        phase <= S_DEV;
        bcnt  <= '0;
        drive <= 1'b0;
        if (!busy) pvalid <= '0;
      end else if (stop_det) begin
        phase <= S_IDLE;
        drive <= 1'b0;
      end else begin
        case (phase)
          S_DEV, S_AHI, S_ALO, S_WDAT: begin
            if (scl_rise && bcnt != 4'd8) begin
              shreg <= {shreg[6:0], sda_s};
              bcnt  <= bcnt + 1'b1;
            end else if (scl_fall && bcnt == 4'd8) begin
              bcnt <= '0;
              case (phase)
                S_DEV: begin
                  if (shreg[7:1] == {DEV_TYPE, dev_strap_i} && !busy) begin
                    drive <= 1'b1;
                    rw    <= shreg[0];
                    phase <= S_DACK;
                  end else begin
                    phase <= S_IDLE;
                  end
                end
                S_AHI: begin
                  ahi   <= shreg;
                  drive <= 1'b1;
                  phase <= S_AHACK;
                end
                S_ALO: begin
                  ptr   <= full_addr[ADDR_W-1:0];
                  drive <= 1'b1;
                  phase <= S_ALACK;
                end
                default: begin
                  pvalid[ptr[PAGE_W-1:0]] <= 1'b1;
                  ptr   <= {ptr[ADDR_W-1:PAGE_W], ptr[PAGE_W-1:0] + 1'b1};
                  drive <= 1'b1;
                  phase <= S_WACK;
                end
              endcase
            end
          end
          S_DACK: if (scl_fall) begin
            if (rw) begin
              tx    <= rd_data;
              drive <= ~rd_data[7];
              ptr   <= ptr + 1'b1;
              bcnt  <= '0;
              phase <= S_RDAT;
            end else begin
              drive <= 1'b0;
              phase <= S_AHI;
            end
          end
          S_AHACK: if (scl_fall) begin drive <= 1'b0; phase <= S_ALO;  end
          S_ALACK: if (scl_fall) begin drive <= 1'b0; phase <= S_WDAT; end
          S_WACK:  if (scl_fall) begin drive <= 1'b0; phase <= S_WDAT; end
          S_RDAT: begin
            if (scl_rise) begin
              bcnt <= bcnt + 1'b1;
            end else if (scl_fall) begin
              if (bcnt == 4'd8) begin
                drive <= 1'b0;
                phase <= S_RACK;
              end else begin
                drive <= ~tx[6];
                tx    <= {tx[6:0], 1'b0};
              end
            end
          end
          S_RACK: begin
            if (scl_rise) begin
              if (sda_s) phase <= S_IDLE;
              else       bcnt  <= 4'd9;
            end else if (scl_fall && bcnt == 4'd9) begin
              tx    <= rd_data;
              drive <= ~rd_data[7];
              ptr   <= ptr + 1'b1;
              bcnt  <= '0;
              phase <= S_RDAT;
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/twi_ee_slave_chk.sv
module twi_ee_slave_chk #(
  parameter int ADDR_W = 12,
  parameter int PAGE_W = 5
) (
  input logic                clk,
  input logic                rst_n,
  input logic                scl_s,
  input logic                stop_det,
  input logic                sda_pull_o,
  input twi_ee_pkg::phase_t  phase,
  input logic                busy,
  input logic                mem_we,
  input logic                wr_take,
  input logic [ADDR_W-1:0]   ptr
);
  import twi_ee_pkg::*;

  AST_NO_ACK_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == S_DACK) |-> !busy); // R2

  AST_COMMIT_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> busy); // R5

  AST_PAGE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    wr_take |=> $stable(ptr[ADDR_W-1:PAGE_W])); // R4

  AST_STOP_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> !sda_pull_o); // R10

  AST_CHANGE_WHEN_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_pull_o) |-> !scl_s); // R10
endmodule

bind twi_ee_slave twi_ee_slave_chk #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .stop_det(stop_det),
  .sda_pull_o(sda_pull_o), .phase(phase), .busy(busy), .mem_we(mem_we),
  .wr_take(wr_take), .ptr(ptr)
);

// File: tb/twi_ee_slave_tb_top.sv
module twi_ee_slave_tb_top;
  localparam int AW = 8;
  localparam int WRC = 300;
  localparam logic [2:0] STRAP = 3'b101;
  localparam logic [7:0] DEV_W = {4'b1010, STRAP, 1'b0};
  localparam logic [7:0] DEV_R = {4'b1010, STRAP, 1'b1};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1;
  logic sda_m = 1'b1;
  logic sda_pull;
  logic sda_line;
  logic quiet_exp = 1'b0;
  int   nchk = 0;
  int   nfail = 0;
  int   mem_m [256];
  int   ptr_m = 0;

  assign sda_line = sda_m & ~sda_pull;
  always #10 clk = ~clk;

  twi_ee_slave #(.ADDR_W(AW), .PAGE_W(5), .WR_CYCLES(WRC)) dut_i (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line),
    .dev_strap_i(STRAP), .sda_pull_o(sda_pull)
  );

  task automatic check(input string tag, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n && quiet_exp) check("R8/R10 line left free", int'(sda_pull), 0);

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic bus_start();
    quiet_exp = 1'b0;
    sda_m = 1'b1; tick(4); scl = 1'b1; tick(8);
    sda_m = 1'b0; tick(8); scl = 1'b0; tick(4);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; tick(4); scl = 1'b1; tick(8);
    sda_m = 1'b1; tick(8);
  endtask

  task automatic put_bit(input logic b);
    sda_m = b; tick(4); scl = 1'b1; tick(8); scl = 1'b0; tick(4);
  endtask

  task automatic get_bit(output logic b);
    sda_m = 1'b1; tick(4); scl = 1'b1; tick(4);
    @(negedge clk); b = sda_line;
    tick(4); scl = 1'b0; tick(4);
  endtask

  task automatic send_byte(input logic [7:0] v, output logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) put_bit(v[i]);
    get_bit(b);
    ack = ~b;
  endtask

  task automatic recv_byte(output logic [7:0] v, input logic mack);
    logic b;
    for (int i = 7; i >= 0; i--) begin get_bit(b); v[i] = b; end
    put_bit(~mack);
  endtask

  task automatic poll(input logic [7:0] dev, input int exp_ack, input string tag);
    logic a;
    bus_start(); send_byte(dev, a); check(tag, int'(a), exp_ack); bus_stop();
  endtask

  task automatic wr_seq(input int addr, input int n, input int seed);
    logic a;
    int off;
    int page;
    page = addr & 8'hE0;
    off = addr & 31;
    bus_start();
    send_byte(DEV_W, a); check("R1 write address ack", int'(a), 1);
    send_byte(8'hC0, a); check("R3 high word byte ack", int'(a), 1);
    send_byte(8'(addr), a); check("R3 low word byte ack", int'(a), 1);
    for (int i = 0; i < n; i++) begin
      int v;
      v = (seed + i * 37) & 255;
      send_byte(8'(v), a); check("R3 data byte ack", int'(a), 1);
      mem_m[page | off] = v;
      off = (off + 1) & 31;
    end
    ptr_m = page | off;
    bus_stop();
    poll(DEV_R, 0, "R2 no ack while writing");
    tick(WRC + 50);
    poll(DEV_W, 1, "R2 ack after write cycle");
  endtask

  task automatic read_bytes(input int n, input string tag);
    logic [7:0] d;
    for (int i = 0; i < n; i++) begin
      recv_byte(d, i < n - 1);
      check(tag, int'(d), mem_m[ptr_m]);
      ptr_m = (ptr_m + 1) & 255;
    end
    quiet_exp = 1'b1;
    bus_stop();
    check("R10 released after stop", int'(sda_pull), 0);
  endtask

  task automatic rd_random(input int addr, input int n, input string tag);
    logic a;
    bus_start();
    send_byte(DEV_W, a); check("R9 header ack", int'(a), 1);
    send_byte(8'hFF, a); check("R3 high byte upper bits ignored", int'(a), 1);
    send_byte(8'(addr), a); check("R9 low byte ack", int'(a), 1);
    ptr_m = addr;
    bus_start();
    send_byte(DEV_R, a); check("R6 read address ack", int'(a), 1);
    read_bytes(n, tag);
  endtask

  task automatic rd_current(input int n, input string tag);
    logic a;
    bus_start();
    send_byte(DEV_R, a); check("R6 current read ack", int'(a), 1);
    read_bytes(n, tag);
  endtask

  initial begin
    logic a;
    tick(5);
    check("R11 line free in reset", int'(sda_pull), 0);
    rst_n = 1'b1;
    tick(5);
    check("R11 line free after reset", int'(sda_pull), 0);

    bus_start();
    send_byte(8'hA0, a); check("R1 foreign address not acked", int'(a), 0);
    quiet_exp = 1'b1;
    send_byte(8'h3C, a); check("R1 silent after mismatch", int'(a), 0);
    bus_stop();

    wr_seq(16'h10, 5, 8'h11);
    rd_random(16'h10, 4, "R9 R8 sequential random read");
    rd_current(1, "R6 current address read");

    wr_seq(16'h20, 8, 8'h5A);
    wr_seq(16'h3F, 3, 8'hC3);
    rd_current(1, "R4 counter wrapped in page");
    rd_random(16'h3F, 1, "R4 last byte of page");
    rd_random(16'h20, 4, "R5 R4 page wrap and untouched bytes");

    wr_seq(16'hFE, 2, 8'h71);
    wr_seq(16'h00, 2, 8'h29);
    rd_random(16'hFE, 4, "R7 read wraps array end");

    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule